// File: doc/BRIEF.md
# Direct-Mapped Write-Through Cache

This block sits between a processor load/store port and a slower, word-wide main memory. It keeps 2^IDX_W lines of 2^OFF_W 32-bit words each. A 32-bit byte address is split into a tag, a line index, a word offset and a 2-bit byte offset. A read is served in the cycle it is presented when the selected line is valid and its stored tag equals the address tag. Otherwise the processor is stalled. Any queued stores to the missing line are pushed out to memory first. The whole line is then fetched one word at a time, the tag and valid bit are written, and the held access is replayed as a hit.

Stores are word-wide and always written through. Each store enters a small write buffer that holds the full word address and data. A store also updates the cached word when it hits. A store that misses leaves the cache untouched. When a store targets a word that is already waiting in the buffer, and that entry is not the one currently presented to memory, the waiting entry takes the new data and no second entry is created. When the buffer is full, a store that cannot merge is held in stall. The processor must keep its request, address and data steady while it is stalled.

Top module: `wt_cache`

## Requirements
- R1: After reset every line is invalid: with no request pending, `cpu_stall` and `mem_req` are low, and the first read of any address stalls.
- R2: The line index is byte-address bits [2+OFF_W+IDX_W-1 : 2+OFF_W] and the tag is bits [31 : 2+OFF_W+IDX_W]. Two addresses with the same index but different tags evict each other. Addresses with different indices do not disturb each other.
- R3: A read of a valid line with a matching tag returns the stored word on `cpu_rdata` with `cpu_stall` low in the same cycle.
- R4: A read miss stalls the processor and reads the whole line from memory, one word per request, in increasing word-offset order (byte address +4 per word). Each request stays asserted with stable address, direction and data until `mem_ack`. After the last word the held read completes with the memory data.
- R5: After a refill, every word of the refilled line hits, including the replayed access in the first cycle after the fetch ends.
- R6: Every accepted store reaches memory with its full address and data. A store that hits also updates the cached word, so a following read of that word hits and returns the new data.
- R7: A store that misses does not allocate: the cache contents are unchanged, and a later read of that line misses and returns the stored data from memory.
- R8: A store to a word already waiting in the write buffer, other than the entry presented to memory, replaces that entry's data. Memory then receives one write for that word, carrying the latest data.
- R9: While the four-entry write buffer is full, a store that cannot merge holds `cpu_stall` high until an entry drains. The store is then accepted.
- R10: A read miss waits until no buffered store to the same line remains before it fetches, so it returns data written by earlier stores.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor access request, held while stalled |
| cpu_we | input | 1 | 1 = word store, 0 = word load |
| cpu_addr | input | 32 | Byte address of the access |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid when request is high and stall is low |
| cpu_stall | output | 1 | Holds the processor; the access completes in a cycle where it is low |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 32 | Word-aligned byte address for memory |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | One-cycle completion of the current memory request |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |

## Verification
A read hit and an accepted store complete in the cycle they are presented. The bench drives each access after a falling edge and samples `cpu_stall` and `cpu_rdata` shortly after that same edge, so a zero stall count marks a hit. On a read miss, the controller enters its drain state one cycle after the miss. It moves to fetch once no store to the line is waiting, issues one request per word, and replays in the cycle after the last acknowledge. The bench therefore waits on `cpu_stall` rather than a fixed count, and separately checks the logged order of memory read addresses. Buffered stores reach memory at least one cycle after acceptance, at a latency the bench memory model chooses. Memory contents and write counts are therefore compared only after an idle interval long enough for the buffer to drain.

// File: rtl/wtc_pkg.sv
package wtc_pkg;

    localparam int ADDR_W  = 32;
    localparam int WORD_W  = 32;
    localparam int BYTE_W  = 2;
    localparam int WADDR_W = ADDR_W - BYTE_W;

    typedef logic [WORD_W-1:0]  word_t;
    typedef logic [WADDR_W-1:0] waddr_t;

    // One pending write-through store
    typedef struct packed {
        waddr_t waddr;
        word_t  data;
    } wb_entry_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DRAIN = 2'd1,
        ST_FETCH = 2'd2
    } fsm_t;

    function automatic waddr_t to_waddr(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:BYTE_W];
    endfunction

endpackage

// File: rtl/wtc_store.sv
module wtc_store
    import wtc_pkg::*;
#(
    parameter int IDX_W = 3,
    parameter int OFF_W = 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [ADDR_W-1:0]       lk_addr,
    output logic                    lk_hit,
    output word_t                   lk_data,
    input  logic                    inv_en,
    input  logic [IDX_W-1:0]        inv_idx,
    input  logic                    tag_we,
    input  logic [IDX_W-1:0]        tag_idx,
    input  logic [ADDR_W-IDX_W-OFF_W-BYTE_W-1:0] tag_val,
    input  logic                    dat_we,
    input  logic [IDX_W+OFF_W-1:0]  dat_widx,
    input  word_t                   dat_wval
);
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W - BYTE_W;
    localparam int LINES = 1 << IDX_W;
    localparam int WORDS = 1 << (IDX_W + OFF_W);

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [IDX_W-1:0]  idx;
        logic [OFF_W-1:0]  off;
        logic [BYTE_W-1:0] byt;
    } addr_f_t;

    logic [LINES-1:0] line_ok;
    logic [TAG_W-1:0] tag_mem [LINES];
    word_t            dat_mem [WORDS];

    addr_f_t lk;
    logic    unused_byte;

    assign lk          = addr_f_t'(lk_addr);
    assign unused_byte = ^lk.byt;
    assign lk_hit      = line_ok[lk.idx] && (tag_mem[lk.idx] == lk.tag);
    assign lk_data     = dat_mem[{lk.idx, lk.off}];

    always_ff @(posedge clk) begin
        if (rst) begin
            line_ok <= '0;
        end else begin
            if (inv_en) line_ok[inv_idx] <= 1'b0;
            if (tag_we) line_ok[tag_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (tag_we) tag_mem[tag_idx] <= tag_val;
    end

    always_ff @(posedge clk) begin
        if (dat_we) dat_mem[dat_widx] <= dat_wval;
    end

endmodule

// File: rtl/wtc_wbuf.sv
module wtc_wbuf
    import wtc_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int OFF_W = 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   push,
    input  wb_entry_t              push_ent,
    output logic                   merge_hit,
    input  logic                   pop,
    output wb_entry_t              head_ent,
    output logic                   empty,
    output logic                   full,
    input  logic [WADDR_W-OFF_W-1:0] probe_line,
    output logic                   probe_pend
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    wb_entry_t        slot [DEPTH];
    logic [DEPTH-1:0] slot_ok;
    logic [PW-1:0]    head, tail;
    logic [DEPTH-1:0] mrg_vec, pend_vec;

    // A store may merge into any waiting entry except the one at the head,
    // which is the entry presented to memory.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mrg_vec[i]  = slot_ok[i] && (i != int'(head)) &&
                          (slot[i].waddr == push_ent.waddr);
            pend_vec[i] = slot_ok[i] && !(pop && (i == int'(head))) &&
                          (slot[i].waddr[WADDR_W-1:OFF_W] == probe_line);
        end
    end

    assign merge_hit  = |mrg_vec;
    assign probe_pend = |pend_vec;
    assign empty      = ~|slot_ok;
    assign full       = &slot_ok;
    assign head_ent   = slot[head];

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_ok <= '0;
            head    <= '0;
            tail    <= '0;
        end else begin
            if (pop && slot_ok[head]) begin
                slot_ok[head] <= 1'b0;
                head <= (head == PW'(DEPTH-1)) ? '0 : head + 1'b1;
            end
            if (push && !merge_hit) begin
                slot_ok[tail] <= 1'b1;
                tail <= (tail == PW'(DEPTH-1)) ? '0 : tail + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            if (merge_hit) begin
                for (int i = 0; i < DEPTH; i++)
                    if (mrg_vec[i]) slot[i].data <= push_ent.data;
            end else begin
                slot[tail] <= push_ent;
            end
        end
    end

endmodule

// File: rtl/wtc_ctrl.sv
module wtc_ctrl
    import wtc_pkg::*;
#(
    parameter int IDX_W = 3,
    parameter int OFF_W = 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cpu_req,
    input  logic                    cpu_we,
    input  logic [ADDR_W-1:0]       cpu_addr,
    input  logic                    lk_hit,
    input  logic                    wb_empty,
    input  logic                    wb_pend,
    input  wb_entry_t               wb_head,
    output logic                    wb_pop,
    output logic [WADDR_W-OFF_W-1:0] miss_line,
    output logic                    busy,
    output logic                    mem_req,
    output logic                    mem_we,
    output logic [ADDR_W-1:0]       mem_addr,
    output word_t                   mem_wdata,
    input  logic                    mem_ack,
    output logic                    fill_we,
    output logic [IDX_W+OFF_W-1:0]  fill_widx,
    output logic                    tag_we,
    output logic [IDX_W-1:0]        tag_idx,
    output logic [ADDR_W-IDX_W-OFF_W-BYTE_W-1:0] tag_val,
    output logic                    inv_en
);
    localparam int LINE_W = WADDR_W - OFF_W;

    fsm_t             state;
    logic [OFF_W-1:0] beat;
    logic             in_fetch, go_fetch, last_beat;
    logic [BYTE_W+OFF_W-1:0] unused_low;

    assign unused_low = cpu_addr[BYTE_W+OFF_W-1:0];
    assign in_fetch   = (state == ST_FETCH);
    assign last_beat  = (beat == {OFF_W{1'b1}});
    // Leave drain only between write transfers and with the line clean
    assign go_fetch   = (state == ST_DRAIN) && !wb_pend && (wb_empty || wb_pop);

    assign busy      = (state != ST_IDLE);
    assign mem_req   = in_fetch || !wb_empty;
    assign mem_we    = !in_fetch;
    assign mem_addr  = in_fetch ? {miss_line, beat, {BYTE_W{1'b0}}}
                                : {wb_head.waddr, {BYTE_W{1'b0}}};
    assign mem_wdata = wb_head.data;
    assign wb_pop    = !in_fetch && !wb_empty && mem_ack;

    assign fill_we   = in_fetch && mem_ack;
    assign fill_widx = {miss_line[IDX_W-1:0], beat};
    assign tag_we    = fill_we && last_beat;
    assign tag_idx   = miss_line[IDX_W-1:0];
    assign tag_val   = miss_line[LINE_W-1:IDX_W];
    assign inv_en    = go_fetch;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            beat      <= '0;
            miss_line <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (cpu_req && !cpu_we && !lk_hit) begin
                        miss_line <= cpu_addr[ADDR_W-1:BYTE_W+OFF_W];
                        state     <= ST_DRAIN;
                    end
                end
                ST_DRAIN: begin
                    if (go_fetch) begin
                        beat  <= '0;
                        state <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (mem_ack) begin
                        beat <= beat + 1'b1;
                        if (last_beat) state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/wt_cache.sv
module wt_cache
    import wtc_pkg::*;
#(
    parameter int IDX_W    = 3,
    parameter int OFF_W    = 1,
    parameter int WB_DEPTH = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cpu_req,
    input  logic        cpu_we,
    input  logic [31:0] cpu_addr,
    input  logic [31:0] cpu_wdata,
    output logic [31:0] cpu_rdata,
    output logic        cpu_stall,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata
);
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W - BYTE_W;

    logic                   lk_hit, busy;
    logic                   wb_empty, wb_full, merge_hit, wb_pend, wb_pop;
    logic                   st_ok, st_push;
    wb_entry_t              wb_head, st_ent;
    logic [WADDR_W-OFF_W-1:0] miss_line;
    logic                   fill_we, tag_we, inv_en, dat_we;
    logic [IDX_W+OFF_W-1:0] fill_widx, dat_widx;
    logic [IDX_W-1:0]       tag_idx;
    logic [TAG_W-1:0]       tag_val;
    word_t                  dat_wval;

    assign st_ok     = !wb_full || merge_hit;
    assign st_push   = cpu_req && cpu_we && !busy && st_ok;
    assign cpu_stall = cpu_req && (busy || (cpu_we ? !st_ok : !lk_hit));

    assign st_ent.waddr = to_waddr(cpu_addr);
    assign st_ent.data  = cpu_wdata;

    // Refill and store-hit writes never coincide: stores wait while busy
    assign dat_we   = fill_we || (st_push && lk_hit);
    assign dat_widx = fill_we ? fill_widx : cpu_addr[BYTE_W +: IDX_W+OFF_W];
    assign dat_wval = fill_we ? mem_rdata : cpu_wdata;

    wtc_store #(.IDX_W(IDX_W), .OFF_W(OFF_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .lk_addr  (cpu_addr),
        .lk_hit   (lk_hit),
        .lk_data  (cpu_rdata),
        .inv_en   (inv_en),
        .inv_idx  (tag_idx),
        .tag_we   (tag_we),
        .tag_idx  (tag_idx),
        .tag_val  (tag_val),
        .dat_we   (dat_we),
        .dat_widx (dat_widx),
        .dat_wval (dat_wval)
    );

    wtc_wbuf #(.DEPTH(WB_DEPTH), .OFF_W(OFF_W)) u_wbuf (
        .clk        (clk),
        .rst        (rst),
        .push       (st_push),
        .push_ent   (st_ent),
        .merge_hit  (merge_hit),
        .pop        (wb_pop),
        .head_ent   (wb_head),
        .empty      (wb_empty),
        .full       (wb_full),
        .probe_line (miss_line),
        .probe_pend (wb_pend)
    );

    wtc_ctrl #(.IDX_W(IDX_W), .OFF_W(OFF_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cpu_req   (cpu_req),
        .cpu_we    (cpu_we),
        .cpu_addr  (cpu_addr),
        .lk_hit    (lk_hit),
        .wb_empty  (wb_empty),
        .wb_pend   (wb_pend),
        .wb_head   (wb_head),
        .wb_pop    (wb_pop),
        .miss_line (miss_line),
        .busy      (busy),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_ack   (mem_ack),
        .fill_we   (fill_we),
        .fill_widx (fill_widx),
        .tag_we    (tag_we),
        .tag_idx   (tag_idx),
        .tag_val   (tag_val),
        .inv_en    (inv_en)
    );

endmodule

// File: rtl/wtc_checker.sv
module wtc_checker #(
    parameter int OFF_W = 1
) (
    input logic        clk,
    input logic        rst,
    input logic        cpu_req,
    input logic        cpu_we,
    input logic        cpu_stall,
    input logic        mem_req,
    input logic        mem_we,
    input logic        mem_ack,
    input logic [31:0] mem_addr,
    input logic [31:0] mem_wdata,
    input logic        busy,
    input logic        wb_full,
    input logic        merge_hit
);
    logic after_rst;

    always_ff @(posedge clk) after_rst <= rst;

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        after_rst |-> !mem_req);                                       // R1

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) &&
                                   $stable(mem_addr) && $stable(mem_wdata))); // R4

    AST_FETCH_ORDER: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we && mem_ack && (mem_addr[2 +: OFF_W] != {OFF_W{1'b1}}))
        |=> (mem_req && !mem_we && (mem_addr == $past(mem_addr) + 32'd4))); // R4

    AST_REPLAY_HITS: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> !cpu_stall);                                   // R5

    AST_FULL_STALL: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && cpu_we && wb_full && !merge_hit) |-> cpu_stall);   // R9

endmodule

bind wt_cache wtc_checker #(.OFF_W(OFF_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cpu_req   (cpu_req),
    .cpu_we    (cpu_we),
    .cpu_stall (cpu_stall),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .busy      (busy),
    .wb_full   (wb_full),
    .merge_hit (merge_hit)
);

// File: tb/wt_cache_bench.sv
module wt_cache_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_stall;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    always #5 clk = ~clk;

    wt_cache u_wt_cache (
        .clk(clk), .rst(rst),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    int checks = 0, failures = 0;
    bit finished = 1'b0;

    logic [31:0] mem_model [1024];
    logic [31:0] shadow    [1024];
    logic [31:0] rd_log [$];
    int          wr_count = 0;
    int          lat_set = 0, wait_cnt = 0, lat_jit = 0;

    logic [31:0] exp_q [$];
    string       tag_q [$];

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Memory model: acknowledges after a variable wait, drives at negedge
    always @(negedge clk) begin
        if (rst) begin
            mem_ack  = 1'b0;
            wait_cnt = 0;
        end else if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (mem_req) begin
            if (wait_cnt >= lat_set + lat_jit) begin
                mem_ack  = 1'b1;
                wait_cnt = 0;
                lat_jit  = (lat_jit == 2) ? 0 : lat_jit + 1;
                if (mem_we) begin
                    mem_model[mem_addr[11:2]] = mem_wdata;
                    wr_count++;
                end else begin
                    mem_rdata = mem_model[mem_addr[11:2]];
                    rd_log.push_back(mem_addr);
                end
            end else begin
                wait_cnt++;
            end
        end
    end

    // Monitor: pops the expected load value when a load completes
    always @(negedge clk) begin
        #1;
        if (!rst && cpu_req && !cpu_stall && !cpu_we) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R3 unexpected load", cpu_rdata, 32'h0);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(cpu_rdata === e, t, cpu_rdata, e);
            end
        end
    end

    // Driver: presents one access and waits until it is taken
    task automatic access(input bit we, input logic [31:0] a, input logic [31:0] d,
                          input string t, output int stalls);
        stalls = 0;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        if (we) shadow[a[11:2]] = d;
        else begin
            exp_q.push_back(shadow[a[11:2]]);
            tag_q.push_back(t);
        end
        forever begin
            #2;
            if (!cpu_stall) break;
            stalls++;
            @(negedge clk);
        end
        @(posedge clk);
        #1 cpu_req = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            checks++; failures++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int s, s2;
        int w0;
        for (int i = 0; i < 1024; i++) begin
            mem_model[i] = 32'h5A00_0000 ^ (i * 32'h0001_0103);
            shadow[i]    = mem_model[i];
        end
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk); #2;
        chk(cpu_stall == 1'b0, "R1 stall idle after reset", {31'b0, cpu_stall}, 32'h0);
        chk(mem_req == 1'b0, "R1 mem_req idle after reset", {31'b0, mem_req}, 32'h0);

        // First read misses and fetches the line in order
        rd_log.delete();
        access(1'b0, 32'h000, 32'h0, "R4 miss data", s);
        chk(s > 0, "R1 first read stalls", s, 32'h1);
        chk(rd_log.size() == 2 && rd_log[0] == 32'h000 && rd_log[1] == 32'h004,
            "R4 fetch order", (rd_log.size() > 1) ? rd_log[1] : 32'hFFFF_FFFF, 32'h004);

        access(1'b0, 32'h004, 32'h0, "R5 other word data", s);
        chk(s == 0, "R5 other word hits", s, 32'h0);
        access(1'b0, 32'h000, 32'h0, "R3 hit data", s);
        chk(s == 0, "R3 repeated read hits", s, 32'h0);

        // Conflicts at the same index, none across indices
        access(1'b0, 32'h040, 32'h0, "R2 conflict data", s);
        chk(s > 0, "R2 same index new tag misses", s, 32'h1);
        access(1'b0, 32'h000, 32'h0, "R2 evicted data", s);
        chk(s > 0, "R2 evicted line misses", s, 32'h1);
        access(1'b0, 32'h008, 32'h0, "R2 other index data", s);
        access(1'b0, 32'h000, 32'h0, "R2 kept data", s);
        chk(s == 0, "R2 other index kept line", s, 32'h0);

        // Store hit updates cache and memory
        access(1'b1, 32'h000, 32'hD1D1_0001, "", s);
        chk(s == 0, "R6 store accepted at once", s, 32'h0);
        access(1'b0, 32'h000, 32'h0, "R6 read after store", s);
        chk(s == 0, "R6 read after store hits", s, 32'h0);
        idle(20);
        chk(mem_model[0] == 32'hD1D1_0001, "R6 store reached memory", mem_model[0], 32'hD1D1_0001);

        // Store miss: no allocate
        access(1'b1, 32'h100, 32'hD2D2_0002, "", s);
        idle(20);
        access(1'b0, 32'h000, 32'h0, "R7 resident line unchanged", s);
        chk(s == 0, "R7 resident line still hits", s, 32'h0);
        access(1'b0, 32'h100, 32'h0, "R7 stored data via memory", s);
        chk(s > 0, "R7 store miss did not allocate", s, 32'h1);

        // Read miss behind a pending store to the same line
        lat_set = 5;
        access(1'b1, 32'h204, 32'hD3D3_0003, "", s);
        access(1'b0, 32'h200, 32'h0, "R10 other word after drain", s);
        access(1'b0, 32'h204, 32'h0, "R10 read returns pending store", s);
        chk(s == 0, "R10 refilled line hits", s, 32'h0);
        idle(30);

        // Merge into a waiting entry
        lat_set = 6;
        w0 = wr_count;
        access(1'b1, 32'h300, 32'hA1A1_0000, "", s);
        access(1'b1, 32'h304, 32'hB1B1_0000, "", s);
        access(1'b1, 32'h304, 32'hB2B2_0000, "", s2);
        chk(s2 == 0, "R8 merging store not stalled", s2, 32'h0);
        access(1'b1, 32'h308, 32'hC1C1_0000, "", s);
        idle(60);
        chk(wr_count - w0 == 3, "R8 one write per merged word", wr_count - w0, 32'h3);
        chk(mem_model[32'h304 >> 2] == 32'hB2B2_0000, "R8 latest data written",
            mem_model[32'h304 >> 2], 32'hB2B2_0000);

        // Full buffer stalls a fifth distinct store
        lat_set = 8;
        s2 = 0;
        for (int k = 0; k < 4; k++) begin
            access(1'b1, 32'h400 + 32'(k * 4), 32'hF000_0000 + 32'(k), "", s);
            s2 += s;
        end
        chk(s2 == 0, "R9 four stores fit", s2, 32'h0);
        access(1'b1, 32'h410, 32'hF000_0004, "", s);
        chk(s > 0, "R9 fifth store stalls while full", s, 32'h1);
        lat_set = 0;
        idle(100);
        chk(mem_model[32'h410 >> 2] == 32'hF000_0004, "R9 stalled store written",
            mem_model[32'h410 >> 2], 32'hF000_0004);

        begin
            int bad = 0;
            for (int i = 0; i < 1024; i++)
                if (mem_model[i] !== shadow[i]) bad++;
            chk(bad == 0, "R6 memory matches all stores", bad, 32'h0);
        end
        chk(exp_q.size() == 0, "R3 all loads completed", exp_q.size(), 32'h0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule